// File: doc/BRIEF.md
# Replay FIFO with Banded Fill Flags

This block is a synchronous first-in first-out buffer, nine bits wide by default, with one write port and one word-read port. The read port is meant to feed a downstream serializer: each accepted read delivers the oldest stored word one clock later. The buffer tracks a write pointer, a read pointer and an occupancy count, and turns the count into four active-low status flags: full, empty, half-full, and a two-sided "edge band" flag. The edge band flag is low when the buffer is nearly drained or nearly full, and high in the comfortable middle.

A replay request (`rtx_n` low) moves the read pointer back to location 0 and leaves the write pointer where it is. Everything written since reset can then be read again. The request is honoured only in a cycle with no read or write request. Occupancy is then set to the write pointer's index, and the flags follow on the next clock.

The flags come from a fill-zone state machine with six states: `Z_EMPTY` (0 words), `Z_LOW` (1 to DEPTH/8), `Z_MIDLO` (DEPTH/8+1 to DEPTH/2), `Z_MIDHI` (DEPTH/2+1 to 7·DEPTH/8−1), `Z_TOP` (7·DEPTH/8 to DEPTH−1) and `Z_FULL` (DEPTH). An accepted write or read moves the machine by one word, so it steps to a neighbouring zone or stays put. A replay can jump it straight to the zone of the write-pointer index. Reset forces `Z_EMPTY`.

Top module: `replay_fifo`

## Requirements
- R1: While `rst_n` is low, and on release, both pointers are at location 0 and the flags read `full_n`=1, `half_n`=1, `empty_n`=0, `edge_n`=0.
- R2: A write request is accepted only while `full_n` is 1. Accepted words are stored in arrival order, whatever the read activity. A write request while full changes neither the stored data nor the occupancy.
- R3: A read request is accepted only while `empty_n` is 1. `rd_data` then shows the oldest unread word in the cycle after acceptance. A read request while empty changes nothing.
- R4: `edge_n` is 0 when occupancy is between 0 and DEPTH/8 inclusive, or between 7·DEPTH/8 and DEPTH inclusive. Otherwise it is 1.
- R5: `half_n` is 0 exactly when occupancy is greater than DEPTH/2.
- R6: `full_n` is 0 only at occupancy DEPTH, and `empty_n` is 0 only at occupancy 0. All flags are registered and reflect the occupancy left by the previous clock edge.
- R7: `rtx_n` low with `wr_en` and `rd_en` both low sets the read pointer to 0 and keeps the write pointer. Occupancy becomes the write pointer's index, and the next read returns the word at location 0. With either request high, `rtx_n` is ignored.
- R8: A write and a read accepted in the same cycle leave the occupancy unchanged.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock, rising edge active |
| rst_n | input | 1 | Asynchronous active-low reset |
| wr_en | input | 1 | Write request |
| wr_data | input | DATA_W | Word to store |
| rd_en | input | 1 | Word read request |
| rd_data | output | DATA_W | Word read, valid the cycle after acceptance |
| rtx_n | input | 1 | Active-low replay request |
| full_n | output | 1 | Low when full |
| empty_n | output | 1 | Low when empty |
| edge_n | output | 1 | Low in the bottom or top eighth of fill |
| half_n | output | 1 | Low when more than half full |

## Verification
A wrong count or a wrong zone shows up on the flags one clock after the edge that caused it. The bench checks every flag every cycle against a model count, so a boundary that is off by one is caught when the fill crosses DEPTH/8, DEPTH/2 or 7·DEPTH/8. A pointer error shows up as a wrong `rd_data` on the next accepted read. A faulty replay shows up as a wrong first word after the rewind, or as flags that do not match the write-pointer index.

// File: rtl/replay_fifo_pkg.sv
package replay_fifo_pkg;
    typedef enum logic [2:0] {
        Z_EMPTY,
        Z_LOW,
        Z_MIDLO,
        Z_MIDHI,
        Z_TOP,
        Z_FULL
    } fill_zone_t;

    typedef struct packed {
        logic full_n;
        logic empty_n;
        logic edge_n;
        logic half_n;
    } flag_set_t;
endpackage

// File: rtl/rf_store.sv
module rf_store #(
    parameter int DATA_W = 9,
    parameter int DEPTH  = 2048,
    localparam int ADDR_W = $clog2(DEPTH)
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              wr_go,
    input  logic [ADDR_W-1:0] wr_addr,
    input  logic [DATA_W-1:0] wr_data,
    input  logic              rd_go,
    input  logic [ADDR_W-1:0] rd_addr,
    output logic [DATA_W-1:0] rd_data
);
    logic [DATA_W-1:0] mem [DEPTH];

    always_ff @(posedge clk) begin
        if (wr_go) begin
            mem[wr_addr] <= wr_data;
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            rd_data <= '0;
        end else if (rd_go) begin
            rd_data <= mem[rd_addr];
        end
    end
endmodule

// File: rtl/rf_pointers.sv
module rf_pointers #(
    parameter int DEPTH = 2048,
    localparam int ADDR_W = $clog2(DEPTH),
    localparam int CNT_W  = ADDR_W + 1
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              wr_req,
    input  logic              rd_req,
    input  logic              rtx_n,
    input  logic              full_n,
    input  logic              empty_n,
    output logic              wr_go,
    output logic              rd_go,
    output logic [ADDR_W-1:0] wr_ptr,
    output logic [ADDR_W-1:0] rd_ptr,
    output logic [CNT_W-1:0]  count,
    output logic [CNT_W-1:0]  next_count
);
    logic rtx_go;

    always_comb begin
        wr_go  = wr_req && full_n;
        rd_go  = rd_req && empty_n;
        rtx_go = !rtx_n && !wr_req && !rd_req;
        if (rtx_go) begin
            next_count = {1'b0, wr_ptr};
        end else begin
            next_count = count + CNT_W'(wr_go) - CNT_W'(rd_go);
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            wr_ptr <= '0;
            rd_ptr <= '0;
            count  <= '0;
        end else begin
            count <= next_count;
            if (wr_go) begin
                wr_ptr <= wr_ptr + 1'b1;
            end
            if (rtx_go) begin
                rd_ptr <= '0;
            end else if (rd_go) begin
                rd_ptr <= rd_ptr + 1'b1;
            end
        end
    end
endmodule

// File: rtl/rf_zone_fsm.sv
module rf_zone_fsm
    import replay_fifo_pkg::*;
#(
    parameter int DEPTH = 2048,
    localparam int CNT_W = $clog2(DEPTH) + 1
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic [CNT_W-1:0] next_count,
    output flag_set_t        flags
);
    localparam logic [CNT_W-1:0] EIGHTH_C = CNT_W'(DEPTH / 8);
    localparam logic [CNT_W-1:0] HALF_C   = CNT_W'(DEPTH / 2);
    localparam logic [CNT_W-1:0] TOP_C    = CNT_W'(DEPTH - DEPTH / 8);
    localparam logic [CNT_W-1:0] DEPTH_C  = CNT_W'(DEPTH);

    fill_zone_t state, state_nx;

    always_comb begin
        if (next_count == '0) begin
            state_nx = Z_EMPTY;
        end else if (next_count <= EIGHTH_C) begin
            state_nx = Z_LOW;
        end else if (next_count <= HALF_C) begin
            state_nx = Z_MIDLO;
        end else if (next_count < TOP_C) begin
            state_nx = Z_MIDHI;
        end else if (next_count < DEPTH_C) begin
            state_nx = Z_TOP;
        end else begin
            state_nx = Z_FULL;
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            state <= Z_EMPTY;
        end else begin
            state <= state_nx;
        end
    end

    always_comb begin
        unique case (state)
            Z_EMPTY: flags = '{full_n: 1'b1, empty_n: 1'b0, edge_n: 1'b0, half_n: 1'b1};
            Z_LOW:   flags = '{full_n: 1'b1, empty_n: 1'b1, edge_n: 1'b0, half_n: 1'b1};
            Z_MIDLO: flags = '{full_n: 1'b1, empty_n: 1'b1, edge_n: 1'b1, half_n: 1'b1};
            Z_MIDHI: flags = '{full_n: 1'b1, empty_n: 1'b1, edge_n: 1'b1, half_n: 1'b0};
            Z_TOP:   flags = '{full_n: 1'b1, empty_n: 1'b1, edge_n: 1'b0, half_n: 1'b0};
            Z_FULL:  flags = '{full_n: 1'b0, empty_n: 1'b1, edge_n: 1'b0, half_n: 1'b0};
            default: flags = '{full_n: 1'b1, empty_n: 1'b0, edge_n: 1'b0, half_n: 1'b1};
        endcase
    end
endmodule

// File: rtl/replay_fifo.sv
module replay_fifo
    import replay_fifo_pkg::*;
#(
    parameter int DATA_W = 9,
    parameter int DEPTH  = 2048
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              wr_en,
    input  logic [DATA_W-1:0] wr_data,
    input  logic              rd_en,
    output logic [DATA_W-1:0] rd_data,
    input  logic              rtx_n,
    output logic              full_n,
    output logic              empty_n,
    output logic              edge_n,
    output logic              half_n
);
    localparam int ADDR_W = $clog2(DEPTH);
    localparam int CNT_W  = ADDR_W + 1;

    logic              wr_go, rd_go;
    logic [ADDR_W-1:0] wr_ptr, rd_ptr;
    logic [CNT_W-1:0]  count, next_count;
    flag_set_t         flags;

    rf_pointers #(.DEPTH(DEPTH)) u_ptrs (
        .clk        (clk),
        .rst_n      (rst_n),
        .wr_req     (wr_en),
        .rd_req     (rd_en),
        .rtx_n      (rtx_n),
        .full_n     (flags.full_n),
        .empty_n    (flags.empty_n),
        .wr_go      (wr_go),
        .rd_go      (rd_go),
        .wr_ptr     (wr_ptr),
        .rd_ptr     (rd_ptr),
        .count      (count),
        .next_count (next_count)
    );

    rf_store #(.DATA_W(DATA_W), .DEPTH(DEPTH)) u_store (
        .clk     (clk),
        .rst_n   (rst_n),
        .wr_go   (wr_go),
        .wr_addr (wr_ptr),
        .wr_data (wr_data),
        .rd_go   (rd_go),
        .rd_addr (rd_ptr),
        .rd_data (rd_data)
    );

    rf_zone_fsm #(.DEPTH(DEPTH)) u_zone (
        .clk        (clk),
        .rst_n      (rst_n),
        .next_count (next_count),
        .flags      (flags)
    );

    assign full_n  = flags.full_n;
    assign empty_n = flags.empty_n;
    assign edge_n  = flags.edge_n;
    assign half_n  = flags.half_n;
endmodule

// File: rtl/replay_fifo_chk.sv
module replay_fifo_chk #(
    parameter int DEPTH = 2048,
    localparam int ADDR_W = $clog2(DEPTH),
    localparam int CNT_W  = ADDR_W + 1
) (
    input logic              clk,
    input logic              rst_n,
    input logic              wr_en,
    input logic              rd_en,
    input logic              rtx_n,
    input logic              full_n,
    input logic              empty_n,
    input logic              edge_n,
    input logic              half_n,
    input logic [CNT_W-1:0]  count,
    input logic [ADDR_W-1:0] wr_ptr,
    input logic [ADDR_W-1:0] rd_ptr
);
    localparam logic [CNT_W-1:0] EIGHTH_C = CNT_W'(DEPTH / 8);
    localparam logic [CNT_W-1:0] HALF_C   = CNT_W'(DEPTH / 2);
    localparam logic [CNT_W-1:0] TOP_C    = CNT_W'(DEPTH - DEPTH / 8);

    // R6
    flags_exclusive_chk: assert property (@(posedge clk) disable iff (!rst_n)
        !(!full_n && !empty_n));

    // R2
    no_overflow_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (!full_n && wr_en && !rd_en) |=> $stable(count));

    // R3
    no_underflow_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (!empty_n && rd_en && !wr_en) |=> $stable(count));

    // R4
    edge_band_chk: assert property (@(posedge clk) disable iff (!rst_n)
        edge_n == !((count <= EIGHTH_C) || (count >= TOP_C)));

    // R5
    half_level_chk: assert property (@(posedge clk) disable iff (!rst_n)
        half_n == !(count > HALF_C));

    // R7
    rewind_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (!rtx_n && !wr_en && !rd_en) |=> (rd_ptr == '0 && wr_ptr == $past(wr_ptr)));

    // R8
    balanced_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (wr_en && rd_en && full_n && empty_n) |=> $stable(count));
endmodule

bind replay_fifo replay_fifo_chk #(.DEPTH(DEPTH)) u_chk (
    .clk     (clk),
    .rst_n   (rst_n),
    .wr_en   (wr_en),
    .rd_en   (rd_en),
    .rtx_n   (rtx_n),
    .full_n  (full_n),
    .empty_n (empty_n),
    .edge_n  (edge_n),
    .half_n  (half_n),
    .count   (count),
    .wr_ptr  (wr_ptr),
    .rd_ptr  (rd_ptr)
);

// File: tb/replay_fifo_tb.sv
module replay_fifo_tb;
    localparam int CLK_P  = 10;
    localparam int DATA_W = 9;
    localparam int DEPTH  = 64;

    logic              clk = 1'b0;
    logic              rst_n = 1'b0;
    logic              wr_en = 1'b0, rd_en = 1'b0, rtx_n = 1'b1;
    logic [DATA_W-1:0] wr_data = '0;
    logic [DATA_W-1:0] rd_data;
    logic              full_n, empty_n, edge_n, half_n;

    int total = 0, bad = 0;
    bit done = 0;

    logic [DATA_W-1:0] m_mem [DEPTH];
    int m_wp = 0, m_rp = 0, m_cnt = 0;

    always #(CLK_P/2) clk = ~clk;

    replay_fifo #(.DATA_W(DATA_W), .DEPTH(DEPTH)) u_dut (
        .clk(clk), .rst_n(rst_n), .wr_en(wr_en), .wr_data(wr_data),
        .rd_en(rd_en), .rd_data(rd_data), .rtx_n(rtx_n),
        .full_n(full_n), .empty_n(empty_n), .edge_n(edge_n), .half_n(half_n)
    );

    function automatic logic exp_edge(int c);
        return !((c <= DEPTH/8) || (c >= DEPTH - DEPTH/8));
    endfunction

    function automatic logic exp_half(int c);
        return !(c > DEPTH/2);
    endfunction

    task automatic check(string tag, int act, int exp);
        total++;
        if (act != exp) begin
            bad++;
            $display("FAIL %s actual=%0d expected=%0d cnt=%0d", tag, act, exp, m_cnt);
        end
    endtask

    task automatic check_flags();
        check("R6 full_n", full_n, (m_cnt == DEPTH) ? 0 : 1);
        check("R6 empty_n", empty_n, (m_cnt == 0) ? 0 : 1);
        check("R4 edge_n", edge_n, exp_edge(m_cnt));
        check("R5 half_n", half_n, exp_half(m_cnt));
    endtask

    // inputs are set at negedge, model updated at posedge, outputs checked at next negedge
    task automatic step(bit w, bit r, bit x, logic [DATA_W-1:0] d);
        bit wgo, rgo, xgo;
        logic [DATA_W-1:0] exp_d;
        wr_en = w; rd_en = r; rtx_n = !x; wr_data = d;
        @(posedge clk);
        wgo = w && (m_cnt < DEPTH);
        rgo = r && (m_cnt > 0);
        xgo = x && !w && !r;
        exp_d = m_mem[m_rp];
        if (wgo) begin m_mem[m_wp] = d; m_wp = (m_wp + 1) % DEPTH; end
        if (xgo) begin
            m_rp = 0; m_cnt = m_wp;
        end else begin
            if (rgo) m_rp = (m_rp + 1) % DEPTH;
            m_cnt = m_cnt + int'(wgo) - int'(rgo);
        end
        @(negedge clk);
        check_flags();
        if (rgo) check("R3 rd_data", rd_data, exp_d);
    endtask

    initial begin
        #(CLK_P * 200000);
        if (!done) begin
            total++; bad++;
            $display("FAIL watchdog actual=timeout expected=finish");
            $display("test done: total=%0d bad=%0d", total, bad);
            $finish;
        end
    end

    initial begin
        void'($urandom(32'd7));
        repeat (3) @(negedge clk);
        // R1 reset state while held and after release
        check("R1 full_n", full_n, 1);
        check("R1 half_n", half_n, 1);
        check("R1 empty_n", empty_n, 0);
        check("R1 edge_n", edge_n, 0);
        rst_n = 1'b1;
        @(negedge clk);
        check_flags();

        // R3 read while empty ignored
        step(0, 1, 0, '0);
        // fill to full across every band boundary, then R2 write while full ignored
        for (int i = 0; i < DEPTH; i++) step(1, 0, 0, DATA_W'(i * 5 + 3));
        step(1, 0, 0, 9'h1AA);
        check("R2 full held", full_n, 0);
        // R8 read and write together at mid level
        for (int i = 0; i < 20; i++) step(0, 1, 0, '0);
        step(1, 1, 0, 9'h055);
        check("R8 count kept via half_n", half_n, exp_half(m_cnt));
        // drain fully, checking order (R2) through rd_data
        while (m_cnt > 0) step(0, 1, 0, '0);
        step(0, 1, 0, '0);

        // R7 replay: fresh reset, write 12, read 5, rewind, read back from location 0
        rst_n = 1'b0; m_wp = 0; m_rp = 0; m_cnt = 0;
        @(negedge clk); rst_n = 1'b1; @(negedge clk);
        for (int i = 0; i < 12; i++) step(1, 0, 0, DATA_W'(100 + i));
        for (int i = 0; i < 5; i++) step(0, 1, 0, '0);
        step(0, 0, 1, '0);
        check("R7 edge_n after rewind", edge_n, exp_edge(12));
        step(0, 1, 0, '0);
        check("R7 first replay word", rd_data, 100);
        // R7 ignored while a read is requested
        step(0, 1, 1, '0);
        check("R7 ignored with read", rd_data, 101);

        // constrained random mix, alternating fill and drain bias
        for (int i = 0; i < 4000; i++) begin
            int pw;
            bit w, r, x;
            pw = ((i / 300) % 2 == 0) ? 70 : 30;
            w = ($urandom % 100) < pw;
            r = ($urandom % 100) < (100 - pw);
            x = ($urandom % 40) == 0;
            step(w, r, x, DATA_W'($urandom));
        end

        done = 1;
        $display("test done: total=%0d bad=%0d", total, bad);
        $finish;
    end
endmodule